// File: doc/BRIEF.md
# Link Interface Restart Sequencer

This block sits on the physical-layer side of the parallel interface between a PHY and its link controller. It brings that interface back into service after a reset or disabled period. While the link's power-status input is low, the interface is held off: the system-clock enable is low, the control and data buses are not driven, and no link request is taken.

When power-status is seen high again, the block first waits out a clock-restore delay. That delay is short when the PHY was awake and long when it was in a low-power state. It then raises the system-clock enable and runs a fixed, cycle-counted handshake on the buses: a forced-low window, then a receive marker with all-ones data, then idle. At that point it declares the interface ready.

Link requests use a valid/ready pair. `req_ready_o` is high only once initialization is complete. A request is taken in any cycle where valid and ready are both high. The requester holds valid until it sees the take pulse, so back-pressure before or during the sequence costs nothing but waiting. Dropping power-status at any moment aborts the sequence and clears readiness.

Top module: `link_restart_seq`

## Requirements
- R1: After reset, `clk_en_o`, `bus_oe_o`, `init_done_o` and `req_ready_o` are 0, and `ctl_o` and `dat_o` are all zeros.
- R2: In any cycle where `lps_i` is sampled low at a clock edge, the next cycle shows `clk_en_o`=0, `bus_oe_o`=0, `ctl_o`=2'b00, `dat_o`=0 and `init_done_o`=0, whatever step the sequence had reached.
- R3: After `lps_i` is first sampled high, `clk_en_o` stays 0 for exactly SHORT_WAKE cycles when `lowpwr_i` was 0 at that edge, and for exactly LONG_WAKE cycles when it was 1. The buses stay undriven during this wait.
- R4: For the first 7 cycles with `clk_en_o`=1, `bus_oe_o`=1 and the buses are forced low (`ctl_o`=2'b00, `dat_o`=0).
- R5: From the eighth enabled cycle, for RX_HOLD cycles (RX_HOLD ≥ 1), `ctl_o`=2'b10 (receive) and `dat_o` is all ones.
- R6: After the receive marker, `ctl_o`=2'b00 (idle) and `dat_o`=0, and `init_done_o` rises. These hold for as long as `lps_i` stays high, and later changes of `lowpwr_i` have no effect.
- R7: `req_ready_o` equals `init_done_o`. `req_take_o` is 1 exactly when `req_valid_i` and `req_ready_o` are both 1, so a request offered before completion is not taken.
- R8: The control code is 2'b00 idle, 2'b01 status, 2'b10 receive, 2'b11 grant. This block only ever drives idle or receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lps_i | input | 1 | Link power-status; high requests the interface be active |
| lowpwr_i | input | 1 | PHY is in a low-power state (selects long restore delay) |
| req_valid_i | input | 1 | Link request offered |
| req_ready_o | output | 1 | Link requests can be taken |
| req_take_o | output | 1 | Request taken this cycle |
| clk_en_o | output | 1 | System-clock enable toward the link |
| bus_oe_o | output | 1 | Drive enable for control and data buses |
| ctl_o | output | 2 | Control bus code |
| dat_o | output | DW | Data bus |
| init_done_o | output | 1 | Interface initialization complete |

## Verification
The bench builds the block with SHORT_WAKE=2, LONG_WAKE=40 and RX_HOLD=3. At these values both restore paths complete within tens of cycles, so every phase boundary can be checked cycle by cycle, in both power states. A multi-cycle receive marker exposes off-by-one errors in its hold count that a single-cycle marker would hide. Random abort points and random request offers then reach every phase with power-status dropping mid-sequence, and exercise requests offered before and after readiness.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_WAKE = 3'd1,
    ST_LOW  = 3'd2,
    ST_RXM  = 3'd3,
    ST_IDLE = 3'd4
  } seq_state_e;

  localparam logic [1:0] CTL_IDLE   = 2'b00;
  localparam logic [1:0] CTL_STATUS = 2'b01;
  localparam logic [1:0] CTL_RECV   = 2'b10;
  localparam logic [1:0] CTL_GRANT  = 2'b11;

  localparam int unsigned LOW_CYCLES = 7;
endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/link_bus_drive.sv
module link_bus_drive
  import lrs_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  seq_state_e    state,
  output logic          clk_en,
  output logic          bus_oe,
  output logic [1:0]    ctl,
  output logic [DW-1:0] dat,
  output logic          done
);
  always_comb begin
    clk_en = 1'b0;
    bus_oe = 1'b0;
    ctl    = CTL_IDLE;
    dat    = '0;
    done   = 1'b0;
    case (state)
      ST_LOW: begin
        clk_en = 1'b1;
        bus_oe = 1'b1;
      end
      ST_RXM: begin
        clk_en = 1'b1;
        bus_oe = 1'b1;
        ctl    = CTL_RECV;
        dat    = '1;
      end
      ST_IDLE: begin
        clk_en = 1'b1;
        bus_oe = 1'b1;
        done   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/link_restart_seq.sv
module link_restart_seq
  import lrs_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned SHORT_WAKE = 3,
  parameter int unsigned LONG_WAKE  = 300000,
  parameter int unsigned RX_HOLD    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lps_i,
  input  logic          lowpwr_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  output logic          req_take_o,
  output logic          clk_en_o,
  output logic          bus_oe_o,
  output logic [1:0]    ctl_o,
  output logic [DW-1:0] dat_o,
  output logic          init_done_o
);
  localparam int unsigned MAX_A  = (LONG_WAKE > SHORT_WAKE) ? LONG_WAKE : SHORT_WAKE;
  localparam int unsigned MAX_B  = (RX_HOLD > LOW_CYCLES) ? RX_HOLD : LOW_CYCLES;
  localparam int unsigned MAX_LD = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW     = $clog2(MAX_LD + 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_WAKE - 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_WAKE - 1);
  localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] RX_LD    = CW'(RX_HOLD - 1);

  seq_state_e    state_q, state_d;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!lps_i) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_d  = ST_WAKE;
          tmr_load = 1'b1;
          tmr_val  = lowpwr_i ? LONG_LD : SHORT_LD;
        end
        ST_WAKE: if (tmr_zero) begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = LOW_LD;
        end
        ST_LOW: if (tmr_zero) begin
          state_d  = ST_RXM;
          tmr_load = 1'b1;
          tmr_val  = RX_LD;
        end
        ST_RXM: if (tmr_zero) state_d = ST_IDLE;
        ST_IDLE: state_d = ST_IDLE;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  seq_countdown #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  link_bus_drive #(.DW(DW)) u_drv (
    .state  (state_q),
    .clk_en (clk_en_o),
    .bus_oe (bus_oe_o),
    .ctl    (ctl_o),
    .dat    (dat_o),
    .done   (init_done_o)
  );

  assign req_ready_o = init_done_o;
  assign req_take_o  = req_valid_i & init_done_o;
endmodule

// File: rtl/link_restart_chk.sv
module link_restart_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lps_i,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          req_take_o,
  input logic          clk_en_o,
  input logic          bus_oe_o,
  input logic [1:0]    ctl_o,
  input logic [DW-1:0] dat_o,
  input logic          init_done_o
);
  // R2
  lps_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lps_i |=> (!clk_en_o && !bus_oe_o && !init_done_o));

  // R4
  first_enabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> (bus_oe_o && ctl_o == 2'b00 && dat_o == '0));

  // R5
  rx_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == 2'b10) |-> (dat_o == {DW{1'b1}} && bus_oe_o));

  // R6
  done_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> ($past(ctl_o) == 2'b10 && ctl_o == 2'b00 && dat_o == '0));

  // R7
  take_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_take_o |-> (req_valid_i && req_ready_o && init_done_o));

  // R8
  ctl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o == 2'b00) || (ctl_o == 2'b10 && bus_oe_o));

  // R3
  undriven_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o |-> (!bus_oe_o && dat_o == '0));
endmodule

bind link_restart_seq link_restart_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lps_i       (lps_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_take_o  (req_take_o),
  .clk_en_o    (clk_en_o),
  .bus_oe_o    (bus_oe_o),
  .ctl_o       (ctl_o),
  .dat_o       (dat_o),
  .init_done_o (init_done_o)
);

// File: tb/sim_link_restart_seq.sv
module sim_link_restart_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int SW = 2;
  localparam int LW = 40;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_i = 1'b0;
  logic lowpwr_i = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o, req_take_o, clk_en_o, bus_oe_o, init_done_o;
  logic [1:0] ctl_o;
  logic [DW-1:0] dat_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_restart_seq #(.DW(DW), .SHORT_WAKE(SW), .LONG_WAKE(LW), .RX_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .lps_i(lps_i), .lowpwr_i(lowpwr_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_take_o(req_take_o),
    .clk_en_o(clk_en_o), .bus_oe_o(bus_oe_o), .ctl_o(ctl_o), .dat_o(dat_o),
    .init_done_o(init_done_o)
  );

  // packed view {clk_en, oe, ctl[1:0], done, dat}
  function automatic logic [12:0] off_vec();
    return 13'd0;
  endfunction

  function automatic logic [12:0] exp_vec(int k, int w);
    if (k < w)                 return 13'd0;
    else if (k < w + 7)        return {1'b1, 1'b1, 2'b00, 1'b0, 8'h00};
    else if (k < w + 7 + HOLD) return {1'b1, 1'b1, 2'b10, 1'b0, 8'hFF};
    else                       return {1'b1, 1'b1, 2'b00, 1'b1, 8'h00};
  endfunction

  task automatic check(string req, logic [12:0] act, logic [12:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string phase_req(int k, int w);
    if (k < w)                 return "R3";
    else if (k < w + 7)        return "R4";
    else if (k < w + 7 + HOLD) return "R5";
    else                       return "R6";
  endfunction

  function automatic logic [12:0] obs();
    return {clk_en_o, bus_oe_o, ctl_o, init_done_o, dat_o};
  endfunction

  // abort_k < 0 means run to completion
  task automatic run_seq(bit lp, int abort_k);
    int w = lp ? LW : SW;
    int last = w + 7 + HOLD + 3;
    @(negedge clk);
    lps_i = 1'b1;
    lowpwr_i = lp;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      lowpwr_i = $urandom_range(0, 1);  // R6: ignored once started
      check(phase_req(k, w), obs(), exp_vec(k, w));
      req_valid_i = $urandom_range(0, 1);
      #1;
      // R7
      check("R7", {11'd0, req_ready_o, req_take_o},
            {11'd0, exp_vec(k, w)[8], req_valid_i & exp_vec(k, w)[8]});
      if (k == abort_k) break;
    end
    lps_i = 1'b0;
    req_valid_i = 1'b1;
    @(negedge clk);
    // R2
    check("R2", obs(), off_vec());
    #1;
    check("R7", {11'd0, req_ready_o, req_take_o}, 13'd0);
    req_valid_i = 1'b0;
    @(negedge clk);
    check("R2", obs(), off_vec());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3);
    // R1
    check("R1", obs(), off_vec());
    check("R1", {11'd0, req_ready_o, req_take_o}, 13'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", obs(), off_vec());
    // directed: both power states, full runs (R3 R4 R5 R6 R8)
    run_seq(1'b0, -1);
    run_seq(1'b1, -1);
    // directed aborts: in wake, forced-low window, receive marker (R2)
    run_seq(1'b1, 5);
    run_seq(1'b0, SW + 3);
    run_seq(1'b0, SW + 7);
    run_seq(1'b0, SW + 7 + HOLD - 1);
    // random mix
    for (int i = 0; i < 30; i++) begin
      bit lp = $urandom_range(0, 1);
      int lim = (lp ? LW : SW) + 7 + HOLD + 2;
      int ab = ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, lim));
      run_seq(lp, ab);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule